// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block generates the read and write addresses for a single DMA channel and tracks how many bytes are still to move. Each side (source and destination) has a start address, an end address and a width code. An end address of zero marks a single-address device, such as a FIFO data register, whose address never changes. Any other end value marks a memory block that is walked in steps of the side's width.

The channel starts when `enable` is raised while idle. From then on, every cycle with `beat_accept` high while the channel is running counts as one beat. On each beat, both addresses and the byte counter advance at the next clock edge.

In single mode, the beat that uses up the length stops the channel and raises `done`. In repeat mode, the byte counter reloads and the channel keeps running until software drops `enable`. A block side that steps past its end address returns to its start address. The step that does so produces a one-cycle wrap pulse, which software can use to count passes.

Top module: `dma_addr_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `active`, `done`, `src_wrap` and `dst_wrap` are low.
- R2: When `enable` is high while the channel is idle, `active` is high in the next cycle. In that cycle the addresses equal their start values and `remaining` equals `xfer_len`. While idle, the addresses track the start inputs and `remaining` tracks `xfer_len`, one cycle late.
- R3: A side whose end address is zero keeps presenting its start address on every beat, in both modes.
- R4: A side whose end address is nonzero advances by its width in bytes on each beat. The width code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes.
- R5: If the advanced address of a block side would exceed its end address, the side instead returns to its start address. Its wrap output (`src_wrap` or `dst_wrap`) is high for exactly the cycle in which the restarted address is presented.
- R6: On each beat, `remaining` drops by the destination width in bytes. Without a beat it holds.
- R7: In single mode (`mode_repeat` low), a beat taken while `remaining` is not above the destination width ends the transfer. In the next cycle `active` is low, `done` is high and `remaining` is 0. `active` and `done` are never high together.
- R8: In repeat mode, that same beat reloads `remaining` with `xfer_len` and the channel stays active. `done` never rises in repeat mode.
- R9: When `enable` is low, the next cycle shows `active` and `done` low and the addresses at their start values, whether the channel was running or finished.
- R10: While `done` is high and `enable` stays high, the channel does not restart and its outputs hold. A new transfer needs `enable` to go low first.
- R11: `beat_accept` has no effect unless the channel is running with `enable` high. Addresses and `remaining` do not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel run request |
| mode_repeat | input | 1 | 1 = repeat mode, 0 = single mode |
| beat_accept | input | 1 | Current addresses were consumed this cycle |
| src_start | input | ADDR_W | Source start address |
| src_end | input | ADDR_W | Source end address (0 = fixed address) |
| src_width | input | 2 | Source width code |
| dst_start | input | ADDR_W | Destination start address |
| dst_end | input | ADDR_W | Destination end address (0 = fixed address) |
| dst_width | input | 2 | Destination width code |
| xfer_len | input | LEN_W | Transfer length in bytes |
| active | output | 1 | Channel is running |
| done | output | 1 | Single-mode transfer finished |
| src_addr | output | ADDR_W | Current read address |
| dst_addr | output | ADDR_W | Current write address |
| remaining | output | LEN_W | Bytes left in the current pass |
| src_wrap | output | 1 | Source block restarted on the last beat |
| dst_wrap | output | 1 | Destination block restarted on the last beat |

## Verification
The following properties are checked on every cycle:
- a fixed side never moves;
- a block side moves by exactly its width;
- each wrap pulse coincides with the start address;
- `remaining` holds when there is no beat;
- `done` rises only from a single-mode beat;
- a low `enable` clears the channel.

Other behaviour depends on a whole transfer, so only the bench scenarios can show it. This covers where the length runs out for each pairing of widths, the reload in repeat mode, how a finished channel refuses to restart, and idle beats being ignored. The bench sweeps every pairing of width codes, fixed and block sides, and both modes.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_RUN  = 2'd1,
    CH_FIN  = 2'd2
  } ch_state_e;

  // width code: 0 -> 1 byte, 1 -> 2 bytes, 2/3 -> 4 bytes
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    width_bytes = 3'd1;
      2'd1:    width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_side_addr.sv
module dma_side_addr
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [1:0]        width_code,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap
);

  localparam int SUM_W = ADDR_W + 1;

  logic             fixed_side;
  logic [SUM_W-1:0] next_sum;
  logic             past_end;

  assign fixed_side = (end_addr == '0);
  assign next_sum   = {1'b0, addr} + SUM_W'(width_bytes(width_code));
  assign past_end   = next_sum > {1'b0, end_addr};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (load) begin
        addr <= start_addr;
      end else if (step) begin
        if (fixed_side) begin
          addr <= start_addr;
        end else if (past_end) begin
          addr <= start_addr;
          wrap <= 1'b1;
        end else begin
          addr <= next_sum[ADDR_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/dma_len_count.sv
module dma_len_count
  import dma_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             repeat_mode,
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       dst_code,
  output logic [LEN_W-1:0] remaining,
  output logic             last_beat
);

  logic [LEN_W-1:0] dec;

  assign dec       = LEN_W'(width_bytes(dst_code));
  assign last_beat = remaining <= dec;

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else if (load) begin
      remaining <= len;
    end else if (step) begin
      if (last_beat) begin
        remaining <= repeat_mode ? len : '0;
      end else begin
        remaining <= remaining - dec;
      end
    end
  end

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              mode_repeat,
  input  logic              beat_accept,
  input  logic [ADDR_W-1:0] src_start,
  input  logic [ADDR_W-1:0] src_end,
  input  logic [1:0]        src_width,
  input  logic [ADDR_W-1:0] dst_start,
  input  logic [ADDR_W-1:0] dst_end,
  input  logic [1:0]        dst_width,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              active,
  output logic              done,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [LEN_W-1:0]  remaining,
  output logic              src_wrap,
  output logic              dst_wrap
);

  localparam int NSIDE = 2;

  ch_state_e state_q, state_d;
  logic      beat_go;
  logic      reload;
  logic      last_beat;
  logic      finish;

  logic [ADDR_W-1:0] side_start [NSIDE];
  logic [ADDR_W-1:0] side_end   [NSIDE];
  logic [1:0]        side_code  [NSIDE];
  logic [ADDR_W-1:0] side_addr  [NSIDE];
  logic              side_wrap  [NSIDE];

  assign beat_go = (state_q == CH_RUN) && enable && beat_accept;
  assign reload  = (state_q == CH_IDLE) || !enable;
  assign finish  = beat_go && last_beat && !mode_repeat;

  always_comb begin
    state_d = state_q;
    case (state_q)
      CH_IDLE: if (enable) state_d = CH_RUN;
      CH_RUN: begin
        if (!enable)     state_d = CH_IDLE;
        else if (finish) state_d = CH_FIN;
      end
      CH_FIN:  if (!enable) state_d = CH_IDLE;
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= CH_IDLE;
    else     state_q <= state_d;
  end

  assign active = (state_q == CH_RUN);
  assign done   = (state_q == CH_FIN);

  assign side_start[0] = src_start;
  assign side_end[0]   = src_end;
  assign side_code[0]  = src_width;
  assign side_start[1] = dst_start;
  assign side_end[1]   = dst_end;
  assign side_code[1]  = dst_width;

  for (genvar gi = 0; gi < NSIDE; gi++) begin : g_side
    dma_side_addr #(
      .ADDR_W(ADDR_W)
    ) u_side (
      .clk       (clk),
      .rst       (rst),
      .load      (reload),
      .step      (beat_go),
      .start_addr(side_start[gi]),
      .end_addr  (side_end[gi]),
      .width_code(side_code[gi]),
      .addr      (side_addr[gi]),
      .wrap      (side_wrap[gi])
    );
  end

  assign src_addr = side_addr[0];
  assign dst_addr = side_addr[1];
  assign src_wrap = side_wrap[0];
  assign dst_wrap = side_wrap[1];

  dma_len_count #(
    .LEN_W(LEN_W)
  ) u_len (
    .clk        (clk),
    .rst        (rst),
    .load       (reload),
    .step       (beat_go),
    .repeat_mode(mode_repeat),
    .len        (xfer_len),
    .dst_code   (dst_width),
    .remaining  (remaining),
    .last_beat  (last_beat)
  );

endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              mode_repeat,
  input logic              beat_accept,
  input logic [ADDR_W-1:0] src_start,
  input logic [ADDR_W-1:0] src_end,
  input logic [1:0]        src_width,
  input logic [ADDR_W-1:0] dst_start,
  input logic [ADDR_W-1:0] dst_end,
  input logic [1:0]        dst_width,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              active,
  input logic              done,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [LEN_W-1:0]  remaining,
  input logic              src_wrap,
  input logic              dst_wrap
);

  // R3
  fixed_src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && src_end == '0 && $stable(src_start)) |-> (src_addr == src_start));

  // R3
  fixed_dst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && dst_end == '0 && $stable(dst_start)) |-> (dst_addr == dst_start));

  // R4
  block_src_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && $past(enable && beat_accept) && src_end != '0
     && !src_wrap && $stable(src_width))
    |-> (src_addr == ADDR_W'($past(src_addr) + ADDR_W'(width_bytes(src_width)))));

  // R4
  block_dst_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && $past(enable && beat_accept) && dst_end != '0
     && !dst_wrap && $stable(dst_width))
    |-> (dst_addr == ADDR_W'($past(dst_addr) + ADDR_W'(width_bytes(dst_width)))));

  // R5
  src_wrap_start_chk: assert property (@(posedge clk) disable iff (rst)
    (src_wrap && $stable(src_start)) |-> (src_addr == src_start));

  // R5
  dst_wrap_start_chk: assert property (@(posedge clk) disable iff (rst)
    (dst_wrap && $stable(dst_start)) |-> (dst_addr == dst_start));

  // R6
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$past(beat_accept) && $stable(xfer_len))
    |-> (remaining == $past(remaining)));

  // R7
  run_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(active && done));

  // R8
  done_from_single_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(beat_accept) && !$past(mode_repeat) && remaining == '0));

  // R9
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!active && !done));

endmodule

bind dma_addr_seq dma_addr_seq_chk #(
  .ADDR_W(ADDR_W),
  .LEN_W (LEN_W)
) u_chk (.*);

// File: tb/dma_addr_seq_tb.sv
module dma_addr_seq_tb;

  localparam int ADDR_W = 16;
  localparam int LEN_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enable = 1'b0;
  logic              mode_repeat = 1'b0;
  logic              beat_accept = 1'b0;
  logic [ADDR_W-1:0] src_start = '0, src_end = '0, dst_start = '0, dst_end = '0;
  logic [1:0]        src_width = '0, dst_width = '0;
  logic [LEN_W-1:0]  xfer_len = '0;
  logic              active, done, src_wrap, dst_wrap;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [LEN_W-1:0]  remaining;

  always #10 clk = ~clk;

  dma_addr_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .mode_repeat(mode_repeat),
    .beat_accept(beat_accept),
    .src_start(src_start), .src_end(src_end), .src_width(src_width),
    .dst_start(dst_start), .dst_end(dst_end), .dst_width(dst_width),
    .xfer_len(xfer_len), .active(active), .done(done),
    .src_addr(src_addr), .dst_addr(dst_addr), .remaining(remaining),
    .src_wrap(src_wrap), .dst_wrap(dst_wrap)
  );

  int n_cmp  = 0;
  int n_fail = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= 200000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run exceeded cycle limit (actual %0d, expected below 200000)", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  // expected model state: 0 idle, 1 run, 2 finished
  int               e_st = 0;
  logic [ADDR_W-1:0] e_src, e_dst;
  logic [LEN_W-1:0]  e_rem;
  logic              e_sw, e_dw;

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic adv(inout logic [ADDR_W-1:0] a, inout logic w,
                     input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] e,
                     input logic [1:0] c);
    if (e == '0) a = s;
    else if (int'(a) + nbytes(c) > int'(e)) begin a = s; w = 1'b1; end
    else a = ADDR_W'(int'(a) + nbytes(c));
  endtask

  task automatic do_load();
    e_src = src_start; e_dst = dst_start; e_rem = xfer_len;
  endtask

  // drive one cycle, update model, check after the edge
  task automatic step(input logic en, input logic bt, input string tag);
    enable = en; beat_accept = bt;
    e_sw = 1'b0; e_dw = 1'b0;
    case (e_st)
      0: begin do_load(); if (en) e_st = 1; end
      1: begin
        if (!en) begin do_load(); e_st = 0; end
        else if (bt) begin
          adv(e_src, e_sw, src_start, src_end, src_width);
          adv(e_dst, e_dw, dst_start, dst_end, dst_width);
          if (int'(e_rem) <= nbytes(dst_width)) begin
            if (mode_repeat) e_rem = xfer_len;
            else begin e_rem = '0; e_st = 2; end
          end else e_rem = LEN_W'(int'(e_rem) - nbytes(dst_width));
        end
      end
      default: if (!en) begin do_load(); e_st = 0; end
    endcase
    @(negedge clk);
    cmp(tag, "active", int'(active), int'(e_st == 1));
    cmp(tag, "done", int'(done), int'(e_st == 2));
    cmp((src_end == '0) ? "R3" : "R4", "src_addr", int'(src_addr), int'(e_src));
    cmp((dst_end == '0) ? "R3" : "R4", "dst_addr", int'(dst_addr), int'(e_dst));
    cmp("R5", "src_wrap", int'(src_wrap), int'(e_sw));
    cmp("R5", "dst_wrap", int'(dst_wrap), int'(e_dw));
    cmp("R6", "remaining", int'(remaining), int'(e_rem));
  endtask

  initial begin
    int lens [3] = '{1, 6, 24};
    rst = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1", "active", int'(active), 0);
    cmp("R1", "done", int'(done), 0);
    cmp("R1", "wrap", int'(src_wrap | dst_wrap), 0);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1", "active after release", int'(active), 0);
    cmp("R1", "done after release", int'(done), 0);
    e_st = 0;

    for (int sw = 0; sw < 4; sw++)
      for (int dw = 0; dw < 4; dw++)
        for (int sf = 0; sf < 2; sf++)
          for (int df = 0; df < 2; df++)
            for (int rp = 0; rp < 2; rp++)
              for (int li = 0; li < 3; li++) begin
                src_width = 2'(sw); dst_width = 2'(dw);
                src_start = 16'h0100; src_end = sf ? 16'h0000 : 16'h010F;
                dst_start = 16'h0200; dst_end = df ? 16'h0000 : 16'h0217;
                mode_repeat = rp[0];
                xfer_len = LEN_W'(lens[li]);
                step(1'b0, 1'b0, "R2");
                step(1'b0, 1'b1, "R11");
                step(1'b1, 1'b0, "R2");
                for (int k = 0; k < 40; k++) begin
                  step(1'b1, (k % 3) != 2, rp ? "R8" : "R7");
                  if (e_st == 2) break;
                end
                if (e_st == 2) begin
                  step(1'b1, 1'b1, "R10");
                  step(1'b1, 1'b1, "R10");
                  step(1'b1, 1'b0, "R11");
                end
                step(1'b0, 1'b1, "R9");
                step(1'b0, 1'b0, "R9");
              end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule